// File: doc/BRIEF.md
# Timer compare-match output controller

This block is an up-counting timer with two compare registers that steers a single output pin. In every cycle where the count enable is high, the counter value is compared against both compare registers. A match on either channel applies that channel's 2-bit action code to an internal output state. The code can hold the state, clear it, set it or invert it. The pin shows that state only while at least one action code is non-zero; otherwise the pin is held at 0.

A match on channel A can also raise a one-cycle start request for an analogue-to-digital converter. A per-instance parameter says whether the trigger-enable control exists. Where it does not, that control bit reads as 1 and no request is ever produced. Software-style access goes through a synchronous write port and a combinational read port. The address selects the counter, either compare register or the control register.

Top module: `tmr_compare_out`

## Requirements
- R1: After reset the pin and the start request are 0, the counter and both compare registers read 0, and the control register reads 0x00 (0x10 on an instance without the trigger control).
- R2: The counter advances by one at each clock edge where `cnt_en` is high and wraps from all-ones to 0. A write to address 0 loads the counter and takes priority over the increment.
- R3: On a cycle where `cnt_en` is high, the counter equals compare A and compare B does not match, the A code in control bits 1:0 acts on the output state at that edge: 00 hold, 01 clear, 10 set, 11 invert. With no match and no control write the pin does not change.
- R4: A match on compare B applies the B code in control bits 3:2, using the same four codes as R3.
- R5: When both channels match in the same cycle, the B code alone decides the action, even when it is 00.
- R6: While control bits 3:0 are all 0 the pin reads 0. The output state keeps its value, so re-enabling the pin shows the state left by the last match.
- R7: The control register holds the A code in bits 1:0 and the B code in bits 3:2. Bit 4 is the trigger enable, or reads 1 where the trigger is absent. Bits 7:5 read 0, and writing them has no effect.
- R8: `adc_start` is high for exactly the one cycle after a clock edge that saw a compare A match with the trigger enabled. It stays low when the trigger is disabled, and always on an instance without the trigger.
- R9: Address 0 is the counter, 1 compare A, 2 compare B and 3 the control register. `rdata` shows the addressed register combinationally, and a write with `wr_en` high updates it at the clock edge.
- R10: With `cnt_en` low no compare match occurs, the counter holds, and the pin does not change unless the control register is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable; gates both counting and compare evaluation |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | W | Write data |
| rdata | output | W | Read data of the addressed register |
| tmo | output | 1 | Timer output pin |
| adc_start | output | 1 | One-cycle converter start request |

## Verification
The assertions take for granted that `cnt_en`, `wr_en` and `addr` are known values at every clock edge after reset. They also assume the control register changes only through the write port, so a cycle with a control write is excluded from the pin-action properties. The stimulus changes every input only at the falling edge, through one task, and always gives each input a defined value. It writes the control register only on explicit write steps. Random stimulus biases compare values and counter loads so that matches, simultaneous matches and the wrap point all occur often.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_FLIP = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_CMPA  = 2'd1,
        REG_CMPB  = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    // Packed so that sel_b lands in bits 3:2 and sel_a in bits 1:0.
    typedef struct packed {
        pin_act_e sel_b;
        pin_act_e sel_a;
    } sel_pair_t;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = load_val;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ref_val,
    output logic         hit
);

    always_comb begin
        hit = en && (cnt == ref_val);
    end

endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit_a,
    input  logic      hit_b,
    input  sel_pair_t sel,
    input  logic      trig_en,
    output logic      pin,
    output logic      adc_pulse
);

    typedef struct packed {
        logic out;
        logic pulse;
    } pin_state_t;

    pin_state_t st_d, st_q;
    pin_act_e   act;

    always_comb begin
        // Channel B overrides channel A whenever it matches.
        if (hit_b) begin
            act = sel.sel_b;
        end else if (hit_a) begin
            act = sel.sel_a;
        end else begin
            act = ACT_HOLD;
        end

        st_d = st_q;
        case (act)
            ACT_LOW:  st_d.out = 1'b0;
            ACT_HIGH: st_d.out = 1'b1;
            ACT_FLIP: st_d.out = ~st_q.out;
            default:  st_d.out = st_q.out;
        endcase
        st_d.pulse = hit_a && trig_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin       = (sel != '0) && st_q.out;
    assign adc_pulse = st_q.pulse;

endmodule

// File: rtl/tmr_compare_out.sv
module tmr_compare_out
    import tmr_pkg::*;
#(
    parameter int W            = 8,
    parameter bit TRIG_CAPABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         tmo,
    output logic         adc_start
);

    localparam int NUM_CH    = 2;
    localparam int CTRL_BITS = 5;
    localparam int PAD_BITS  = W - CTRL_BITS;

    typedef struct packed {
        logic [W-1:0] cmp_a;
        logic [W-1:0] cmp_b;
        sel_pair_t    sel;
        logic         trig;
    } regs_t;

    regs_t        regs_d, regs_q;
    reg_sel_e     acc_sel;
    logic         cnt_load;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cmp_vals [NUM_CH];
    logic [NUM_CH-1:0] hit;
    logic [3:0]   sel_bits;
    logic         trig_eff;
    logic         flag_rd;

    assign acc_sel  = reg_sel_e'(addr);
    assign cnt_load = wr_en && (acc_sel == REG_COUNT);

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (acc_sel)
                REG_CMPA: regs_d.cmp_a = wdata;
                REG_CMPB: regs_d.cmp_b = wdata;
                REG_CTRL: begin
                    regs_d.sel  = sel_pair_t'(wdata[3:0]);
                    regs_d.trig = wdata[4] && TRIG_CAPABLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    tmr_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cnt_en),
        .load     (cnt_load),
        .load_val (wdata),
        .cnt      (cnt_q)
    );

    assign cmp_vals[0] = regs_q.cmp_a;
    assign cmp_vals[1] = regs_q.cmp_b;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
        tmr_match #(.W(W)) u_match (
            .en      (cnt_en),
            .cnt     (cnt_q),
            .ref_val (cmp_vals[g]),
            .hit     (hit[g])
        );
    end

    if (TRIG_CAPABLE) begin : g_trig
        assign trig_eff = regs_q.trig;
        assign flag_rd  = regs_q.trig;
    end else begin : g_no_trig
        assign trig_eff = 1'b0;
        assign flag_rd  = 1'b1;
    end

    assign sel_bits = regs_q.sel;

    tmr_pin_ctrl u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_a     (hit[0]),
        .hit_b     (hit[1]),
        .sel       (regs_q.sel),
        .trig_en   (trig_eff),
        .pin       (tmo),
        .adc_pulse (adc_start)
    );

    always_comb begin
        case (acc_sel)
            REG_COUNT: rdata = cnt_q;
            REG_CMPA:  rdata = regs_q.cmp_a;
            REG_CMPB:  rdata = regs_q.cmp_b;
            default:   rdata = {{PAD_BITS{1'b0}}, flag_rd, regs_q.sel};
        endcase
    end

endmodule

// File: rtl/tmr_compare_out_chk.sv
module tmr_compare_out_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] cnt,
    input logic         hit_a,
    input logic         hit_b,
    input logic [3:0]   sel,
    input logic         trig,
    input logic         tmo,
    input logic         adc_start
);

    logic ctrl_wr;
    logic cnt_wr;
    assign ctrl_wr = wr_en && (addr == 2'd3);
    assign cnt_wr  = wr_en && (addr == 2'd0);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && !cnt_wr |=> cnt == ($past(cnt) + {{(W-1){1'b0}}, 1'b1}));

    assert_a_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a && !hit_b && sel[1:0] == 2'b01 && !ctrl_wr |=> !tmo);

    assert_a_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a && !hit_b && sel[1:0] == 2'b10 && !ctrl_wr |=> tmo);

    assert_a_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a && !hit_b && sel[1:0] == 2'b11 && !ctrl_wr |=> tmo != $past(tmo));

    assert_no_match_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_a && !hit_b && !ctrl_wr |=> $stable(tmo));

    assert_b_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b && sel[3:2] == 2'b10 && !ctrl_wr |=> tmo);

    assert_b_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b && sel[3:2] == 2'b01 && !ctrl_wr |=> !tmo);

    assert_b_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a && hit_b && sel[3:2] == 2'b01 && sel[1:0] == 2'b10 && !ctrl_wr |=> !tmo);

    assert_pin_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 4'b0000 |-> !tmo);

    assert_start_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(hit_a && trig));

    assert_start_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a && trig |=> adc_start);

    assert_idle_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en && !ctrl_wr |=> $stable(tmo));

endmodule

bind tmr_compare_out tmr_compare_out_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .cnt       (cnt_q),
    .hit_a     (hit[0]),
    .hit_b     (hit[1]),
    .sel       (sel_bits),
    .trig      (trig_eff),
    .tmo       (tmo),
    .adc_start (adc_start)
);

// File: tb/test_tmr_compare_out.sv
module test_tmr_compare_out;

    localparam int W = 8;

    logic         clk    = 1'b0;
    logic         rst_n  = 1'b0;
    logic         cnt_en = 1'b0;
    logic         wr_en  = 1'b0;
    logic [1:0]   addr   = 2'd0;
    logic [W-1:0] wdata  = '0;
    logic [W-1:0] rdata, rdata_r;
    logic         tmo, adc_start, tmo_r, adc_start_r;

    always #2 clk = ~clk;

    tmr_compare_out #(.W(W), .TRIG_CAPABLE(1'b1)) i_tmr_compare_out (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tmo(tmo), .adc_start(adc_start)
    );

    tmr_compare_out #(.W(W), .TRIG_CAPABLE(1'b0)) i_tmr_compare_out_rsv (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_r), .tmo(tmo_r), .adc_start(adc_start_r)
    );

    // Reference model state
    logic [W-1:0] m_cnt = '0, m_a = '0, m_b = '0;
    logic [3:0]   m_sel = '0;
    logic         m_trig = 1'b0, m_out = 1'b0, m_pulse = 1'b0;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_rd(input logic [1:0] ad, input bit rsv);
        case (ad)
            2'd0:    return m_cnt;
            2'd1:    return m_a;
            2'd2:    return m_b;
            default: return {3'b000, (rsv ? 1'b1 : m_trig), m_sel};
        endcase
    endfunction

    function automatic logic exp_pin();
        return (m_sel != 4'd0) && m_out;
    endfunction

    function automatic logic [1:0] pick_act(input logic ha, input logic hb);
        if (hb)      return m_sel[3:2];
        else if (ha) return m_sel[1:0];
        else         return 2'b00;
    endfunction

    task automatic step(input logic en, input logic we, input logic [1:0] ad,
                        input logic [W-1:0] wd, input string req);
        logic ha, hb;
        logic [1:0] act;
        @(negedge clk);
        cnt_en = en; wr_en = we; addr = ad; wdata = wd;
        #1;
        chk({req, " R9 rdata"}, rdata, exp_rd(ad, 1'b0));
        chk({req, " R7 rdata reserved"}, rdata_r, exp_rd(ad, 1'b1));
        @(posedge clk);
        ha  = en && (m_cnt == m_a);
        hb  = en && (m_cnt == m_b);
        act = pick_act(ha, hb);
        case (act)
            2'b01:   m_out = 1'b0;
            2'b10:   m_out = 1'b1;
            2'b11:   m_out = ~m_out;
            default: ;
        endcase
        m_pulse = ha && m_trig;
        if (we && ad == 2'd0)      m_cnt = wd;
        else if (en)               m_cnt = m_cnt + 1'b1;
        if (we && ad == 2'd1) m_a = wd;
        if (we && ad == 2'd2) m_b = wd;
        if (we && ad == 2'd3) begin
            m_sel  = wd[3:0];
            m_trig = wd[4];
        end
        #1;
        chk({req, " pin"}, W'(tmo), W'(exp_pin()));
        chk({req, " R8 start"}, W'(adc_start), W'(m_pulse));
        chk({req, " pin reserved"}, W'(tmo_r), W'(exp_pin()));
        chk({req, " R8 start reserved"}, W'(adc_start_r), '0);
    endtask

    task automatic wr(input logic [1:0] ad, input logic [W-1:0] wd, input string req);
        step(1'b0, 1'b1, ad, wd, req);
    endtask

    task automatic run(input int n, input logic en, input string req);
        for (int i = 0; i < n; i++) step(en, 1'b0, 2'(i), '0, req);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: state during and just after reset
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pin in reset", W'(tmo), '0);
        chk("R1 start in reset", W'(adc_start), '0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) step(1'b0, 1'b0, 2'(a), '0, "R1 reset read");

        // R3 R4 R7: A clears, B sets, junk in bits 7:5, trigger on
        wr(2'd1, 8'd5, "R9 cmpA");
        wr(2'd2, 8'd9, "R9 cmpB");
        wr(2'd3, 8'hF9, "R7 ctrl write");
        step(1'b0, 1'b0, 2'd3, '0, "R7 ctrl read");
        wr(2'd0, 8'd0, "R2 load");
        run(14, 1'b1, "R3 R4 R8 run");

        // R3 toggle through wrap (R2)
        wr(2'd3, 8'h03, "R3 ctrl toggle");
        wr(2'd1, 8'hFF, "R3 cmpA top");
        wr(2'd0, 8'hFD, "R2 load near top");
        run(5, 1'b1, "R2 wrap R3 toggle");
        step(1'b0, 1'b0, 2'd0, '0, "R2 wrapped count");

        // R5: both match, A sets and B clears; first make out high
        wr(2'd3, 8'h02, "R5 ctrl A high");
        wr(2'd1, 8'h20, "R5 cmpA");
        wr(2'd0, 8'h20, "R5 load");
        run(2, 1'b1, "R5 preset high");
        wr(2'd2, 8'h20, "R5 cmpB");
        wr(2'd3, 8'h06, "R5 ctrl A high B low");
        wr(2'd0, 8'h1F, "R5 load");
        run(3, 1'b1, "R5 both match");
        // R5: B code 00 holds even when A would set
        wr(2'd3, 8'h12, "R5 ctrl B hold");
        wr(2'd0, 8'h20, "R5 load");
        run(2, 1'b1, "R5 B hold wins");

        // R6: disable with state high, re-enable keeps it
        wr(2'd3, 8'h02, "R6 ctrl A high");
        wr(2'd0, 8'h20, "R6 load");
        run(2, 1'b1, "R6 set high");
        wr(2'd3, 8'h00, "R6 disable");
        wr(2'd0, 8'h20, "R6 load");
        run(3, 1'b1, "R6 disabled pin");
        wr(2'd3, 8'h0C, "R6 reenable");
        run(2, 1'b0, "R6 retained");

        // R10: count enable low at a matching value
        wr(2'd3, 8'h13, "R10 ctrl toggle trig");
        wr(2'd0, 8'h20, "R10 load");
        run(5, 1'b0, "R10 idle");
        run(1, 1'b1, "R10 single enable R8");
        // R8: trigger disabled
        wr(2'd3, 8'h03, "R8 trig off");
        wr(2'd0, 8'h20, "R8 load");
        run(2, 1'b1, "R8 no start");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic         en, we;
            logic [1:0]   ad;
            logic [W-1:0] wd;
            int unsigned  r;
            r  = $urandom_range(0, 99);
            en = ($urandom_range(0, 9) < 7);
            we = (r < 15);
            ad = 2'($urandom_range(0, 3));
            wd = 8'($urandom);
            if (we && ad != 2'd3 && $urandom_range(0, 1) == 1) wd = 8'($urandom_range(0, 15));
            step(en, we, ad, wd, "R9 random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule